// File: doc/BRIEF.md
# Serial Memory I2C Target Controller

This block is the bus-facing control logic of a two-wire serial memory. It receives already-synchronised SCL and SDA levels together with single-cycle start and stop event pulses. It decides when to pull the shared data line low, and it turns bus sessions into memory actions. A write session passes each accepted data byte, with its target address, to a separate page buffer engine. At the stop that closes the session it asks that engine to commit. A read session fetches bytes from the array through a simple address/data read port and shifts them out MSB first.

The controller keeps one internal address pointer that survives from one session to the next. A read with no address phase therefore continues where the last access left off. While the memory reports an internal write in progress, the controller answers nothing, so a host can poll with repeated address bytes until it gets an acknowledge. A write-protect input is captured once per write session. A protected session has its first data byte refused and nothing is forwarded.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The address byte is acknowledged only when bits 7..4 equal 4'b1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 selects the direction: 0 is write and 1 is read. Acknowledge means `sda_oe_o` is high during the ninth SCL clock that follows the byte.
- R2: While the master is shifting a byte in, `sda_oe_o` stays low. The controller drives SDA only in an acknowledge slot or while it is sending read data.
- R3: In a write session the controller acknowledges the high address byte, the low address byte and every data byte. For each data byte it gives one `wr_load_o` pulse carrying the byte and its target address.
- R4: Successive data bytes of one write session go to successive addresses within a page of 2^PAGE_W bytes. At the page end the address wraps to the page start, and a later byte overwrites an earlier one.
- R5: `wr_commit_o` pulses once, in the cycle after `stop_i`, only when the session forwarded at least one data byte. A repeated start or a session with no data byte produces no commit.
- R6: While `busy_i` is high when an address byte completes, that byte is not acknowledged and SDA stays released for the rest of the session.
- R7: `wp_i` is captured on the SCL falling edge that closes the low-address acknowledge slot. If it was high then, the first data byte is not acknowledged and no byte of the session is loaded or committed. A change of `wp_i` after that edge has no effect.
- R8: Read data leaves MSB first. Each bit changes on an SCL falling edge. A read issued right after a start returns the byte at the current pointer.
- R9: A write-direction address phase carrying two address bytes, followed by a repeated start and a read-direction address, returns data from the newly loaded address. Bits of the high address byte above ADDR_W are ignored.
- R10: A master acknowledge after a read byte makes the next byte follow from the next address. The address wraps from 2^ADDR_W-1 to 0. A master no-acknowledge ends the output.
- R11: The pointer advances by one after each byte written or each complete byte read, and it keeps its value across sessions. A byte cut short by a stop does not advance it.
- R12: A start or stop event in any state releases SDA. A start returns the controller to address reception and a stop returns it to idle. A start wins over an SCL edge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| start_i | input | 1 | One-cycle start (or repeated start) event |
| stop_i | input | 1 | One-cycle stop event |
| strap_i | input | 3 | Address strap inputs matched against address bits 3..1 |
| wp_i | input | 1 | Write protect, active high |
| busy_i | input | 1 | Internal write in progress |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |
| rd_addr_o | output | ADDR_W | Array read address (current pointer) |
| rd_data_i | input | 8 | Array read data, valid before the next SCL fall |
| wr_load_o | output | 1 | One-cycle pulse: forward a data byte to the page buffer |
| wr_addr_o | output | ADDR_W | Target address of the forwarded byte |
| wr_data_o | output | 8 | Forwarded data byte |
| wr_commit_o | output | 1 | One-cycle pulse: start the internal write |

## Verification
Two pairs of functions can fall in the same clock cycle. A start pulse can coincide with an SCL falling edge, and a pointer advance from a master acknowledge can race the fetch of the next read byte. The bench drives start together with the SCL fall in the middle of an address byte. It judges the result by a released SDA and a correctly acknowledged read that follows. A sequential read across the top of the array, and a read cut short by a stop, show that the fetch always uses the advanced pointer and that an incomplete byte leaves the pointer alone.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  localparam logic [3:0] SLV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } ctl_state_e;

  // address byte selects this target
  function automatic logic slave_hit(input logic [7:0] b, input logic [2:0] strap);
    return (b[7:4] == SLV_PREFIX) && (b[3:1] == strap);
  endfunction

  // bit of the transmit byte to present after clock number cnt
  function automatic logic [2:0] tx_index(input logic [CNT_W-1:0] cnt);
    return 3'(CNT_W'(BYTE_W - 1) - cnt);
  endfunction

endpackage

// File: rtl/eei2c_scl_edge.sv
module eei2c_scl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_i;
  end

  assign rise_o = scl_i & ~scl_q;
  assign fall_o = ~scl_i & scl_q;

endmodule

// File: rtl/eei2c_bit_seq.sv
module eei2c_bit_seq #(
  parameter int BITS = 8,
  localparam int CW  = $clog2(BITS + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            sda_i,
  output logic [CW-1:0]   cnt_o,
  output logic [BITS-1:0] rx_byte_o,
  output logic            byte_fall_o,
  output logic            ninth_rise_o,
  output logic            slot_end_o,
  output logic            bit_fall_o
);
  localparam logic [CW-1:0] LAST_BIT = CW'(BITS);
  localparam logic [CW-1:0] SLOT     = CW'(BITS + 1);

  logic [CW-1:0]   cnt_q;
  logic [BITS-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (rise_i) begin
      if (cnt_q < LAST_BIT) rx_q <= {rx_q[BITS-2:0], sda_i};
      if (cnt_q <= LAST_BIT) cnt_q <= cnt_q + 1'b1;
    end else if (fall_i && cnt_q == SLOT) begin
      cnt_q <= '0;
    end
  end

  assign cnt_o        = cnt_q;
  assign rx_byte_o    = rx_q;
  assign byte_fall_o  = fall_i && (cnt_q == LAST_BIT);
  assign ninth_rise_o = rise_i && (cnt_q == LAST_BIT);
  assign slot_end_o   = fall_i && (cnt_q == SLOT);
  assign bit_fall_o   = fall_i && (cnt_q != '0) && (cnt_q < LAST_BIT);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SLOT);

  // R12
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0);

endmodule

// File: rtl/eei2c_ptr.sv
module eei2c_ptr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              adv_wr_i,
  input  logic              adv_rd_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] p);
    logic [PAGE_W-1:0] off;
    off = p[PAGE_W-1:0] + 1'b1;
    return {p[ADDR_W-1:PAGE_W], off};
  endfunction

  function automatic logic [ADDR_W-1:0] array_next(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (load_i)   ptr_q <= load_val_i;
    else if (adv_wr_i) ptr_q <= page_next(ptr_q);
    else if (adv_rd_i) ptr_q <= array_next(ptr_q);
  end

  assign ptr_o = ptr_q;

  // R4
  page_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_wr_i && !load_i) |=> ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]));

  // R10
  array_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_rd_i && !load_i && !adv_wr_i && ptr_q == '1) |=> ptr_q == '0);

  // R11
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_wr_i && !adv_rd_i) |=> $stable(ptr_q));

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wr_load_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o
);
  import eei2c_pkg::*;

  localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(BYTE_W);

  // named events shared with the assertions
  logic             scl_rise, scl_fall;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       rx_byte;
  logic             byte_fall, ninth_rise, slot_end, bit_fall;
  logic             quiet, dev_ok, ptr_load, adv_wr, adv_rd;
  logic [ADDR_W-1:0] ptr, load_val;

  ctl_state_e        st_q;
  logic              rw_q, wp_lat_q, wr_pend_q, sda_oe_q;
  logic [7:0]        hi_q, tx_q, wr_data_q;
  logic              wr_load_q, wr_commit_q;
  logic [ADDR_W-1:0] wr_addr_q;

  eei2c_scl_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  eei2c_bit_seq #(.BITS(BYTE_W)) u_bits (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (start_i | stop_i),
    .rise_i       (scl_rise),
    .fall_i       (scl_fall),
    .sda_i        (sda_i),
    .cnt_o        (cnt),
    .rx_byte_o    (rx_byte),
    .byte_fall_o  (byte_fall),
    .ninth_rise_o (ninth_rise),
    .slot_end_o   (slot_end),
    .bit_fall_o   (bit_fall)
  );

  eei2c_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ptr_load),
    .load_val_i (load_val),
    .adv_wr_i   (adv_wr),
    .adv_rd_i   (adv_rd),
    .ptr_o      (ptr)
  );

  always_comb begin
    quiet    = !start_i && !stop_i;
    dev_ok   = slave_hit(rx_byte, strap_i) && !busy_i;
    load_val = ADDR_W'({hi_q, rx_byte});
    ptr_load = quiet && byte_fall && (st_q == ST_ALO);
    adv_wr   = quiet && byte_fall && (st_q == ST_WDAT) && !wp_lat_q;
    adv_rd   = quiet && ninth_rise && (st_q == ST_RDAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rw_q        <= 1'b0;
      wp_lat_q    <= 1'b0;
      wr_pend_q   <= 1'b0;
      sda_oe_q    <= 1'b0;
      hi_q        <= '0;
      tx_q        <= '0;
      wr_load_q   <= 1'b0;
      wr_commit_q <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      wr_load_q   <= 1'b0;
      wr_commit_q <= 1'b0;
      if (start_i) begin
        st_q      <= ST_DEV;
        sda_oe_q  <= 1'b0;
        wr_pend_q <= 1'b0;
      end else if (stop_i) begin
        st_q        <= ST_IDLE;
        sda_oe_q    <= 1'b0;
        wr_commit_q <= wr_pend_q;
        wr_pend_q   <= 1'b0;
      end else begin
        if (byte_fall) begin
          case (st_q)
            ST_DEV: begin
              if (dev_ok) begin
                sda_oe_q <= 1'b1;
                rw_q     <= rx_byte[0];
              end else begin
                st_q <= ST_SKIP;
              end
            end
            ST_AHI: begin
              sda_oe_q <= 1'b1;
              hi_q     <= rx_byte;
            end
            ST_ALO: sda_oe_q <= 1'b1;
            ST_WDAT: begin
              if (!wp_lat_q) begin
                sda_oe_q  <= 1'b1;
                wr_load_q <= 1'b1;
                wr_addr_q <= ptr;
                wr_data_q <= rx_byte;
                wr_pend_q <= 1'b1;
              end else begin
                st_q <= ST_SKIP;
              end
            end
            ST_RDAT: sda_oe_q <= 1'b0;
            default: ;
          endcase
        end
        if (ninth_rise && st_q == ST_RDAT && sda_i) st_q <= ST_SKIP;
        if (slot_end) begin
          sda_oe_q <= 1'b0;
          case (st_q)
            ST_DEV: begin
              if (rw_q) begin
                st_q     <= ST_RDAT;
                tx_q     <= rd_data_i;
                sda_oe_q <= ~rd_data_i[7];
              end else begin
                st_q <= ST_AHI;
              end
            end
            ST_AHI: st_q <= ST_ALO;
            ST_ALO: begin
              st_q     <= ST_WDAT;
              wp_lat_q <= wp_i;
            end
            ST_RDAT: begin
              tx_q     <= rd_data_i;
              sda_oe_q <= ~rd_data_i[7];
            end
            default: ;
          endcase
        end
        if (bit_fall && st_q == ST_RDAT) sda_oe_q <= ~tx_q[tx_index(cnt)];
      end
    end
  end

  assign sda_oe_o    = sda_oe_q;
  assign rd_addr_o   = ptr;
  assign wr_load_o   = wr_load_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign wr_commit_o = wr_commit_q;

  // R1
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && byte_fall && st_q == ST_DEV && !slave_hit(rx_byte, strap_i)) |=> !sda_oe_o);

  // R2
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o && st_q != ST_RDAT) |-> cnt >= ACK_CNT);

  // R5
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> $past(stop_i));

  // R6
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && byte_fall && st_q == ST_DEV && busy_i) |=> !sda_oe_o);

  // R7
  wp_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load_o |-> !wp_lat_q);

  // R12
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!sda_oe_o && st_q == ST_DEV));

  // R12
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (!sda_oe_o && st_q == ST_IDLE));

endmodule

// File: tb/tb_eeprom_i2c_slave.sv
module tb_eeprom_i2c_slave;

  localparam int AW = 8;
  localparam int PW = 3;
  localparam int MEM_N = 1 << AW;
  localparam int BUSY_CYC = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, start_p = 1'b0, stop_p = 1'b0;
  logic [2:0] strap = 3'b000;
  logic wp = 1'b0;
  logic busy;
  logic sda_oe, wr_load, wr_commit;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic sda;

  always #2 clk = ~clk;

  assign sda = sda_m & ~sda_oe;

  eeprom_i2c_slave #(.ADDR_W(AW), .PAGE_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .start_i(start_p), .stop_i(stop_p), .strap_i(strap), .wp_i(wp),
    .busy_i(busy), .sda_oe_o(sda_oe), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_load_o(wr_load), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_commit_o(wr_commit)
  );

  // environment: array, staging buffer, busy timer
  logic [7:0] mem [MEM_N];
  logic [7:0] stage [MEM_N];
  logic       stage_v [MEM_N];
  int busy_cnt = 0, n_load = 0, n_commit = 0, bad_drive = 0;
  int last_wa = 0, last_wd = 0;
  logic in_send = 1'b0;

  assign busy = (busy_cnt != 0);
  assign rd_data = mem[rd_addr];

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = init_val(i);
      stage_v[i] = 1'b0;
      stage[i] = 8'h00;
    end
  end

  always @(posedge clk) begin
    if (in_send && sda_oe) bad_drive++;
    if (wr_load) begin
      stage[wr_addr] = wr_data;
      stage_v[wr_addr] = 1'b1;
      n_load++;
      last_wa = int'(wr_addr);
      last_wd = int'(wr_data);
    end
    if (wr_commit) begin
      for (int i = 0; i < MEM_N; i++) begin
        if (stage_v[i]) mem[i] = stage[i];
        stage_v[i] = 1'b0;
      end
      n_commit++;
      busy_cnt = BUSY_CYC;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
    end
  end

  // expected model
  logic [7:0] exp_mem [MEM_N];
  int exp_ptr = 0;
  int n_chk = 0, n_fail = 0;

  initial for (int i = 0; i < MEM_N; i++) exp_mem[i] = init_val(i);

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    tick(2);
    scl = 1'b1;
    tick(4);
    sda_m = 1'b0;
    start_p = 1'b1;
    tick(1);
    start_p = 1'b0;
    tick(3);
    scl = 1'b0;
    tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    tick(4);
    scl = 1'b1;
    tick(4);
    sda_m = 1'b1;
    stop_p = 1'b1;
    tick(1);
    stop_p = 1'b0;
    tick(6);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    in_send = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      tick(4);
      scl = 1'b1;
      tick(8);
      scl = 1'b0;
      tick(1);
    end
    in_send = 1'b0;
    sda_m = 1'b1;
    tick(4);
    scl = 1'b1;
    tick(4);
    ack = ~sda;
    tick(4);
    scl = 1'b0;
    tick(4);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1;
      tick(4);
      scl = 1'b1;
      tick(4);
      b[i] = sda;
      tick(4);
      scl = 1'b0;
    end
    tick(2);
    sda_m = ~mack;
    tick(2);
    scl = 1'b1;
    tick(8);
    scl = 1'b0;
    tick(2);
    sda_m = 1'b1;
    tick(2);
  endtask

  localparam logic [7:0] DEV_W = 8'hAA;  // 1010 101 0
  localparam logic [7:0] DEV_R = 8'hAB;

  task automatic set_addr(input int hi, input int lo);
    logic a;
    bus_start();
    send_byte(DEV_W, a);
    check("R3 dev ack", a, 1);
    send_byte(8'(hi), a);
    check("R3 hi ack", a, 1);
    send_byte(8'(lo), a);
    check("R3 lo ack", a, 1);
    exp_ptr = lo;
  endtask

  task automatic wait_ready(input string tag);
    logic a;
    int polls;
    polls = 0;
    for (int k = 0; k < 40; k++) begin
      bus_start();
      send_byte(DEV_W, a);
      polls++;
      bus_stop();
      if (a) break;
    end
    check({tag, " first poll refused"}, int'(polls > 1), 1);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic a;
    logic [7:0] b;
    int base, loads0, commits0, p;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // reset state
    check("R2 reset sda_oe", sda_oe, 0);
    check("R5 reset commit", wr_commit, 0);
    check("R3 reset load", wr_load, 0);

    // R1: sweep straps against every address code, plus a wrong prefix
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int c = 0; c < 8; c++) begin
        bus_start();
        send_byte({4'b1010, 3'(c), 1'b0}, a);
        check($sformatf("R1 strap=%0d code=%0d", s, c), a, int'(c == s));
        bus_stop();
      end
      bus_start();
      send_byte({4'b1011, 3'(s), 1'b0}, a);
      check("R1 wrong prefix", a, 0);
      bus_stop();
    end
    check("R5 no commit without data", n_commit, 0);
    strap = 3'b101;

    // R3 byte write, then R6 polling
    set_addr(0, 8'h21);
    send_byte(8'hC3, a);
    check("R3 data ack", a, 1);
    bus_stop();
    exp_mem[8'h21] = 8'hC3;
    exp_ptr = 8'h22;
    check("R3 load count", n_load, 1);
    check("R3 load addr", last_wa, 8'h21);
    check("R3 load data", last_wd, 8'hC3);
    check("R5 commit once", n_commit, 1);
    wait_ready("R6");

    // R8 current-address read continues from pointer (R11)
    bus_start();
    send_byte(DEV_R, a);
    check("R8 read ack", a, 1);
    recv_byte(1'b0, b);
    check("R8 R11 current read", b, exp_mem[exp_ptr]);
    bus_stop();
    exp_ptr = (exp_ptr + 1) & 8'hFF;

    // R9 selective read
    set_addr(0, 8'h21);
    bus_start();
    send_byte(DEV_R, a);
    recv_byte(1'b0, b);
    check("R9 selective read", b, 8'hC3);
    bus_stop();
    exp_ptr = 8'h22;

    // R4 page write wrapping; high byte bits above the width ignored (R9)
    base = 8'h4E;
    loads0 = n_load;
    set_addr(8'hFF, base);
    for (int i = 0; i < 11; i++) begin
      send_byte(8'((16 + i * 7) & 8'hFF), a);
      check("R4 page data ack", a, 1);
      exp_mem[(base & 8'hF8) | ((base + i) & 7)] = 8'((16 + i * 7) & 8'hFF);
    end
    bus_stop();
    exp_ptr = (base & 8'hF8) | ((base + 11) & 7);
    check("R4 loads forwarded", n_load - loads0, 11);
    wait_ready("R6 page");
    bus_start();
    send_byte(DEV_R, a);
    recv_byte(1'b0, b);
    check("R11 pointer after page write", b, exp_mem[exp_ptr]);
    bus_stop();
    set_addr(0, 8'h48);
    bus_start();
    send_byte(DEV_R, a);
    for (int i = 0; i < 8; i++) begin
      recv_byte(i != 7, b);
      check($sformatf("R4 R10 page byte %0d", i), b, exp_mem[8'h48 + i]);
    end
    bus_stop();

    // R10 sequential read across the top of the array
    set_addr(0, 8'hFD);
    bus_start();
    send_byte(DEV_R, a);
    for (int i = 0; i < 5; i++) begin
      recv_byte(i != 4, b);
      check($sformatf("R10 wrap byte %0d", i), b, exp_mem[(8'hFD + i) & 8'hFF]);
    end
    bus_stop();
    exp_ptr = 2;
    bus_start();
    send_byte(DEV_R, a);
    recv_byte(1'b0, b);
    check("R11 pointer after wrap", b, exp_mem[exp_ptr]);
    bus_stop();

    // R7 write protect captured before first data byte
    loads0 = n_load;
    commits0 = n_commit;
    wp = 1'b1;
    set_addr(0, 8'h30);
    send_byte(8'h99, a);
    check("R7 protected data refused", a, 0);
    bus_stop();
    wp = 1'b0;
    check("R7 no load", n_load - loads0, 0);
    check("R7 no commit", n_commit - commits0, 0);
    bus_start();
    send_byte(DEV_R, a);
    check("R6 idle after refused write", a, 1);
    recv_byte(1'b0, b);
    check("R7 R11 cell unchanged", b, exp_mem[8'h30]);
    bus_stop();
    // wp raised only after the capture edge: write proceeds
    set_addr(0, 8'h31);
    wp = 1'b1;
    send_byte(8'h66, a);
    check("R7 late wp ignored", a, 1);
    bus_stop();
    wp = 1'b0;
    exp_mem[8'h31] = 8'h66;
    wait_ready("R7");
    set_addr(0, 8'h31);
    bus_start();
    send_byte(DEV_R, a);
    recv_byte(1'b0, b);
    check("R7 late wp write landed", b, 8'h66);
    bus_stop();

    // R5 repeated start discards staged data
    commits0 = n_commit;
    set_addr(0, 8'h40);
    send_byte(8'h55, a);
    check("R3 data ack before restart", a, 1);
    bus_start();
    send_byte(DEV_R, a);
    recv_byte(1'b0, b);
    check("R11 pointer after staged byte", b, exp_mem[8'h41]);
    bus_stop();
    check("R5 restart no commit", n_commit - commits0, 0);
    set_addr(0, 8'h40);
    bus_start();
    send_byte(DEV_R, a);
    recv_byte(1'b0, b);
    check("R5 cell kept", b, exp_mem[8'h40]);
    bus_stop();
    exp_ptr = 8'h41;

    // R12 start coinciding with an SCL falling edge mid-byte
    set_addr(0, 8'h10);
    exp_ptr = 8'h10;
    bus_start();
    send_byte(DEV_W, a);
    send_byte(8'h00, a);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b1;
      tick(4);
      scl = 1'b1;
      tick(8);
      if (i < 2) begin
        scl = 1'b0;
        tick(1);
      end
    end
    scl = 1'b0;
    start_p = 1'b1;
    tick(1);
    start_p = 1'b0;
    tick(3);
    check("R12 released after start", sda_oe, 0);
    send_byte(DEV_R, a);
    check("R12 ack after collided start", a, 1);
    recv_byte(1'b0, b);
    check("R12 read after collided start", b, exp_mem[exp_ptr]);
    bus_stop();
    exp_ptr = exp_ptr + 1;

    // R12 stop in the middle of a read byte; R11 pointer not advanced
    p = exp_ptr;
    bus_start();
    send_byte(DEV_R, a);
    for (int i = 0; i < 3; i++) begin
      tick(4);
      scl = 1'b1;
      tick(8);
      scl = 1'b0;
    end
    tick(4);
    scl = 1'b1;
    tick(4);
    stop_p = 1'b1;
    tick(1);
    stop_p = 1'b0;
    tick(3);
    check("R12 released after stop", sda_oe, 0);
    bus_start();
    send_byte(DEV_R, a);
    recv_byte(1'b0, b);
    check("R11 partial read keeps pointer", b, exp_mem[p]);
    bus_stop();

    check("R2 no drive while master sends", bad_drive, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule